// File: doc/BRIEF.md
# Programmable Event Performance Counter Bank

This block holds a small bank of event counters, each steered by a 32-bit function word. Every clock, an event-source port delivers one occurrence count per event type and a flag saying whether the agent runs in kernel or user mode. For every counter and every cycle, the block decides whether to count. The decision uses the selected event, a threshold that can be inverted, separate gating for user and kernel mode, an optional edge mode, a per-counter enable and a bank-wide enable.

A free-running 64-bit cycle counter runs alongside the event counters. Software writes function words through a small write port. It reads any function word, event counter or the cycle counter through a combinational read port. A one-cycle request captures every event counter together with the cycle count in the same clock edge, so a measurement can be time-stamped exactly.

Top module: `evt_perf_bank`

## Requirements
- R1: While reset is held, every function word, every event counter, the cycle counter, the captured snapshot and `snap_valid` read as zero.
- R2: A function word places the event select in bits [7:0], the unit mask in [15:8], the flags in [23:16] and the threshold in [31:24]. Flag bits 3, 4 and 5 are reserved and always read back as zero; every other bit reads back as written. Read addresses 0..N-1 return the function words, N..2N-1 return the event counters zero-extended, and 2N returns the cycle counter.
- R3: With a threshold of zero and neither edge (flag bit 2) nor invert (flag bit 7) set, a counter adds the full event count of every cycle.
- R4: With a non-zero threshold and invert clear, a counter adds one in each cycle whose event count is at least the threshold.
- R5: With invert set, a counter adds one in each cycle whose event count is no more than the threshold.
- R6: Flag bit 0 allows counting when `in_kernel` is 0, and flag bit 1 allows counting when `in_kernel` is 1. A counter with both bits clear never changes.
- R7: With edge set, a counter adds one only in a qualifying cycle that follows a non-qualifying one.
- R8: A counter changes only while flag bit 6 is set both in its own function word and in counter 0's function word.
- R9: An event select that is not below NUM_EVT sees an event count of zero.
- R10: Writing a function word clears that counter's edge history, so a condition that is already qualifying counts once more in edge mode.
- R11: An event counter wraps to zero modulo 2^CTR_W (40 bits by default).
- R12: The cycle counter starts at zero after reset and adds one on every clock.
- R13: A pulse on `snap_req` raises `snap_valid` for the next cycle. The snapshot then holds every counter and the cycle count as they stood at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt | input | NUM_EVT*EC_W | Per-event occurrence counts for the current cycle, event e at bits [e*EC_W +: EC_W] |
| in_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| fn_we | input | 1 | Function word write strobe |
| fn_idx | input | IW | Counter whose function word is written |
| fn_wdata | input | 32 | Function word write data |
| rd_addr | input | AW | Read address |
| rd_data | output | TSC_W | Combinational read data |
| snap_req | input | 1 | Snapshot capture request |
| snap_valid | output | 1 | Snapshot was captured at the previous edge |
| snap_tsc | output | TSC_W | Captured cycle count |
| snap_ctr | output | NUM_CTR*CTR_W | Captured event counters, counter i at [i*CTR_W +: CTR_W] |

## Verification
The counting rule is driven with short per-cycle sequences of event counts. Each sequence mixes values below, equal to and above the threshold, so an off-by-one in the compare, a swapped invert sense or an add-one in place of an add-count gives a different total. The edge sequences include runs of repeated qualifying cycles, which separate edge counting from level counting. Mode, per-counter enable and bank enable patterns each hold one gate closed while events keep arriving. A narrow second instance is filled past its top to expose the wrap.

// File: rtl/evt_pc_pkg.sv
package evt_pc_pkg;

   typedef struct packed {
      logic [7:0] thresh;
      logic [7:0] flags;
      logic [7:0] umask;
      logic [7:0] evsel;
   } pc_fn_t;

   localparam int unsigned FL_USER = 0;
   localparam int unsigned FL_KERN = 1;
   localparam int unsigned FL_EDGE = 2;
   localparam int unsigned FL_EN   = 6;
   localparam int unsigned FL_INV  = 7;

   localparam logic [7:0] FL_LEGAL = 8'hC7;

   function automatic pc_fn_t pc_clean(input logic [31:0] raw);
      pc_fn_t f;
      f        = pc_fn_t'(raw);
      f.flags  = f.flags & FL_LEGAL;
      return f;
   endfunction

endpackage

// File: rtl/evt_pc_tsc.sv
module evt_pc_tsc #(
   parameter int unsigned TSC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TSC_W-1:0] tsc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) tsc_q <= '0;
      else        tsc_q <= tsc_q + TSC_W'(1);
   end
endmodule

// File: rtl/evt_pc_unit.sv
module evt_pc_unit
   import evt_pc_pkg::*;
#(
   parameter int unsigned CTR_W   = 40,
   parameter int unsigned EC_W    = 4,
   parameter int unsigned NUM_EVT = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fn_wr,
   input  pc_fn_t                    fn_wdata,
   input  logic                      glob_en,
   input  logic                      in_kernel,
   input  logic [NUM_EVT*EC_W-1:0]   evt_bus,
   output pc_fn_t                    fn_q,
   output logic [CTR_W-1:0]          ctr_q
);
   localparam int unsigned CMP_W = (EC_W > 8) ? EC_W : 8;

   logic [EC_W-1:0]  sel_cnt;
   logic [CMP_W-1:0] cnt_w, thr_w;
   logic             thr_zero, thr_hit, inv_hit, qual, mode_ok, qual_m;
   logic             full_step, bump, prev_q;
   logic [CTR_W-1:0] incr;

   always_comb begin
      sel_cnt = '0;
      for (int e = 0; e < NUM_EVT; e++) begin
         if (fn_q.evsel == 8'(e)) sel_cnt = evt_bus[e*EC_W +: EC_W];
      end
   end

   always_comb begin
      cnt_w     = CMP_W'(sel_cnt);
      thr_w     = CMP_W'(fn_q.thresh);
      thr_zero  = (fn_q.thresh == 8'd0);
      thr_hit   = thr_zero ? (sel_cnt != '0) : (cnt_w >= thr_w);
      inv_hit   = (cnt_w <= thr_w);
      qual      = fn_q.flags[FL_INV] ? inv_hit : thr_hit;
      mode_ok   = in_kernel ? fn_q.flags[FL_KERN] : fn_q.flags[FL_USER];
      qual_m    = qual & mode_ok;
      full_step = thr_zero & ~fn_q.flags[FL_INV] & ~fn_q.flags[FL_EDGE];
      incr      = full_step ? CTR_W'(sel_cnt) : CTR_W'(1);
      bump      = glob_en & fn_q.flags[FL_EN] &
                  (fn_q.flags[FL_EDGE] ? (qual_m & ~prev_q) : qual_m);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q   <= '0;
         ctr_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         if (fn_wr) begin
            fn_q   <= fn_wdata;
            prev_q <= 1'b0;
         end else begin
            prev_q <= qual_m;
         end
         if (bump) ctr_q <= ctr_q + incr;
      end
   end
endmodule

// File: rtl/evt_perf_bank.sv
module evt_perf_bank
   import evt_pc_pkg::*;
#(
   parameter int unsigned NUM_CTR = 4,
   parameter int unsigned CTR_W   = 40,
   parameter int unsigned TSC_W   = 64,
   parameter int unsigned EC_W    = 4,
   parameter int unsigned NUM_EVT = 8,
   localparam int unsigned IW     = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
   localparam int unsigned AW     = $clog2(2*NUM_CTR + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_EVT*EC_W-1:0]   evt_cnt,
   input  logic                      in_kernel,
   input  logic                      fn_we,
   input  logic [IW-1:0]             fn_idx,
   input  logic [31:0]               fn_wdata,
   input  logic [AW-1:0]             rd_addr,
   output logic [TSC_W-1:0]          rd_data,
   input  logic                      snap_req,
   output logic                      snap_valid,
   output logic [TSC_W-1:0]          snap_tsc,
   output logic [NUM_CTR*CTR_W-1:0]  snap_ctr
);
   if (CTR_W < EC_W || CTR_W > TSC_W) begin : g_bad_ctr_w
      $error("CTR_W must lie between EC_W and TSC_W");
   end
   if (TSC_W < 32) begin : g_bad_tsc_w
      $error("TSC_W must be at least 32");
   end
   if (NUM_EVT < 1 || NUM_EVT > 256) begin : g_bad_evt
      $error("NUM_EVT must be 1..256");
   end
   if (NUM_CTR < 1) begin : g_bad_ctr
      $error("NUM_CTR must be at least 1");
   end

   pc_fn_t                   fn_arr [NUM_CTR];
   logic [NUM_CTR*32-1:0]    fn_flat;
   logic [NUM_CTR*CTR_W-1:0] ctr_flat;
   logic [TSC_W-1:0]         tsc_q;
   logic                     glob_en;
   pc_fn_t                   fn_clean;

   assign fn_clean = pc_clean(fn_wdata);
   assign glob_en  = fn_arr[0].flags[FL_EN];

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic wr_this;
      assign wr_this = fn_we && (fn_idx == IW'(i));
      evt_pc_unit #(
         .CTR_W   (CTR_W),
         .EC_W    (EC_W),
         .NUM_EVT (NUM_EVT)
      ) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .fn_wr     (wr_this),
         .fn_wdata  (fn_clean),
         .glob_en   (glob_en),
         .in_kernel (in_kernel),
         .evt_bus   (evt_cnt),
         .fn_q      (fn_arr[i]),
         .ctr_q     (ctr_flat[i*CTR_W +: CTR_W])
      );
      assign fn_flat[i*32 +: 32] = fn_arr[i];
   end

   evt_pc_tsc #(.TSC_W(TSC_W)) u_tsc (
      .clk   (clk),
      .rst_n (rst_n),
      .tsc_q (tsc_q)
   );

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (rd_addr == AW'(i))
            rd_data = TSC_W'(fn_flat[i*32 +: 32]);
         if (rd_addr == AW'(NUM_CTR + i))
            rd_data = TSC_W'(ctr_flat[i*CTR_W +: CTR_W]);
      end
      if (rd_addr == AW'(2*NUM_CTR)) rd_data = tsc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_valid <= 1'b0;
         snap_tsc   <= '0;
         snap_ctr   <= '0;
      end else begin
         snap_valid <= snap_req;
         if (snap_req) begin
            snap_tsc <= tsc_q;
            snap_ctr <= ctr_flat;
         end
      end
   end
endmodule

// File: rtl/evt_perf_bank_chk.sv
module evt_perf_bank_chk #(
   parameter int unsigned NUM_CTR = 4,
   parameter int unsigned CTR_W   = 40,
   parameter int unsigned TSC_W   = 64
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [TSC_W-1:0]          tsc_q,
   input logic [NUM_CTR*CTR_W-1:0]  ctr_flat,
   input logic [NUM_CTR*32-1:0]     fn_flat,
   input logic                      glob_en,
   input logic                      snap_valid,
   input logic [TSC_W-1:0]          snap_tsc
);
   logic rsvd_any;
   always_comb begin
      rsvd_any = 1'b0;
      for (int i = 0; i < NUM_CTR; i++)
         rsvd_any = rsvd_any | (|(fn_flat[i*32+16 +: 8] & 8'h38));
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsvd_any);                                                        // R2
   AST_TSC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tsc_q == $past(tsc_q) + TSC_W'(1));                        // R12
   AST_BANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> $stable(ctr_flat));                                    // R8
   AST_SNAP_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid |-> snap_tsc == $past(tsc_q));                           // R13

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_c
      AST_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
         (fn_flat[i*32+16 +: 2] == 2'b00) |=>
            $stable(ctr_flat[i*CTR_W +: CTR_W]));                         // R6
      AST_EDGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         fn_flat[i*32+18] |=>
            CTR_W'(ctr_flat[i*CTR_W +: CTR_W] - $past(ctr_flat[i*CTR_W +: CTR_W]))
               <= CTR_W'(1));                                             // R7
   end
endmodule

bind evt_perf_bank evt_perf_bank_chk #(
   .NUM_CTR (NUM_CTR),
   .CTR_W   (CTR_W),
   .TSC_W   (TSC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tsc_q      (tsc_q),
   .ctr_flat   (ctr_flat),
   .fn_flat    (fn_flat),
   .glob_en    (glob_en),
   .snap_valid (snap_valid),
   .snap_tsc   (snap_tsc)
);

// File: tb/evt_perf_bank_tb.sv
module evt_perf_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_cnt = '0;
   logic        in_kernel = 1'b0;
   logic        fn_we = 1'b0;
   logic [1:0]  fn_idx = '0;
   logic [31:0] fn_wdata = '0;
   logic [3:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic        snap_req = 1'b0;
   logic        snap_valid;
   logic [63:0] snap_tsc;
   logic [159:0] snap_ctr;

   logic [7:0]  w_evt = '0;
   logic        w_we = 1'b0;
   logic [0:0]  w_idx = '0;
   logic [31:0] w_wdata = '0;
   logic [1:0]  w_rd_addr = '0;
   logic [63:0] w_rd_data;
   logic        w_snap_valid;
   logic [63:0] w_snap_tsc;
   logic [7:0]  w_snap_ctr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evt_perf_bank u_dut (
      .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .in_kernel(in_kernel),
      .fn_we(fn_we), .fn_idx(fn_idx), .fn_wdata(fn_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data), .snap_req(snap_req),
      .snap_valid(snap_valid), .snap_tsc(snap_tsc), .snap_ctr(snap_ctr)
   );

   evt_perf_bank #(.NUM_CTR(1), .CTR_W(8), .NUM_EVT(2)) u_dut_w (
      .clk(clk), .rst_n(rst_n), .evt_cnt(w_evt), .in_kernel(1'b0),
      .fn_we(w_we), .fn_idx(w_idx), .fn_wdata(w_wdata),
      .rd_addr(w_rd_addr), .rd_data(w_rd_data), .snap_req(1'b0),
      .snap_valid(w_snap_valid), .snap_tsc(w_snap_tsc), .snap_ctr(w_snap_ctr)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_fn(input int idx, input logic [31:0] v);
      fn_we = 1'b1; fn_idx = 2'(idx); fn_wdata = v;
      @(negedge clk);
      fn_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [63:0] v);
      rd_addr = 4'(a);
      #1;
      v = rd_data;
   endtask

   task automatic set_evt(input int ev, input int val);
      evt_cnt[ev*4 +: 4] = 4'(val);
   endtask

   task automatic seq_delta(input int ev, input int ctr, input int n,
                            input int v [8], output logic [63:0] d);
      logic [63:0] b, a;
      rd(4 + ctr, b);
      for (int k = 0; k < n; k++) begin
         set_evt(ev, v[k]);
         @(negedge clk);
      end
      rd(4 + ctr, a);
      set_evt(ev, 0);
      d = a - b;
   endtask

   task automatic test_reset();
      logic [63:0] v;
      for (int i = 0; i < 4; i++) begin
         rd(i, v);     chk("R1 fn reset", v, 64'd0);
         @(negedge clk);
         rd(4 + i, v); chk("R1 ctr reset", v, 64'd0);
         @(negedge clk);
      end
      chk("R1 snap_valid reset", {63'd0, snap_valid}, 64'd0);
      chk("R1 snap_ctr reset", {63'd0, |snap_ctr}, 64'd0);
      rd(8, v); chk("R12 tsc in reset", v, 64'd0);
   endtask

   task automatic test_full();
      logic [63:0] d;
      wr_fn(0, 32'h0043_0002);
      seq_delta(2, 0, 5, '{3,3,3,3,3,0,0,0}, d); chk("R3 full count", d, 64'd15);
      seq_delta(2, 0, 4, '{1,0,5,15,0,0,0,0}, d); chk("R3 mixed count", d, 64'd21);
   endtask

   task automatic test_thresh();
      logic [63:0] d;
      wr_fn(1, 32'h0443_0001);
      seq_delta(1, 1, 6, '{2,4,7,3,5,0,0,0}, d); chk("R4 threshold", d, 64'd3);
   endtask

   task automatic test_invert();
      logic [63:0] d;
      wr_fn(2, 32'h02C3_0003);
      seq_delta(3, 2, 5, '{0,1,2,3,5,0,0,0}, d); chk("R5 inverted threshold", d, 64'd3);
   endtask

   task automatic test_mode();
      logic [63:0] d;
      wr_fn(3, 32'h0041_0000);
      in_kernel = 1'b1; seq_delta(0, 3, 3, '{2,2,2,0,0,0,0,0}, d); chk("R6 user-only in kernel", d, 64'd0);
      in_kernel = 1'b0; seq_delta(0, 3, 3, '{2,2,2,0,0,0,0,0}, d); chk("R6 user-only in user", d, 64'd6);
      wr_fn(3, 32'h0042_0000);
      seq_delta(0, 3, 2, '{2,2,0,0,0,0,0,0}, d); chk("R6 kernel-only in user", d, 64'd0);
      in_kernel = 1'b1; seq_delta(0, 3, 2, '{2,2,0,0,0,0,0,0}, d); chk("R6 kernel-only in kernel", d, 64'd4);
      wr_fn(3, 32'h0040_0000);
      seq_delta(0, 3, 2, '{2,2,0,0,0,0,0,0}, d); chk("R6 no mode kernel", d, 64'd0);
      in_kernel = 1'b0; seq_delta(0, 3, 2, '{2,2,0,0,0,0,0,0}, d); chk("R6 no mode user", d, 64'd0);
   endtask

   task automatic test_edge();
      logic [63:0] d;
      wr_fn(1, 32'h0047_0001);
      seq_delta(1, 1, 7, '{1,1,0,2,3,0,1,0}, d); chk("R7 edge count", d, 64'd3);
   endtask

   task automatic test_edge_clear();
      logic [63:0] b, a;
      set_evt(1, 1);
      repeat (3) @(negedge clk);
      rd(5, b);
      repeat (3) @(negedge clk);
      rd(5, a); chk("R7 held level no count", a - b, 64'd0);
      @(negedge clk);
      wr_fn(1, 32'h0047_0001);
      repeat (3) @(negedge clk);
      rd(5, b); chk("R10 write re-arms edge", b - a, 64'd1);
      set_evt(1, 0);
      @(negedge clk);
   endtask

   task automatic test_enable();
      logic [63:0] d;
      wr_fn(3, 32'h0043_0000);
      wr_fn(0, 32'h0003_0002);
      seq_delta(0, 3, 4, '{3,3,3,3,0,0,0,0}, d); chk("R8 bank disabled ctr3", d, 64'd0);
      seq_delta(2, 0, 2, '{2,2,0,0,0,0,0,0}, d); chk("R8 bank disabled ctr0", d, 64'd0);
      wr_fn(0, 32'h0043_0002);
      seq_delta(0, 3, 2, '{3,3,0,0,0,0,0,0}, d); chk("R8 bank re-enabled", d, 64'd6);
      wr_fn(3, 32'h0003_0000);
      seq_delta(0, 3, 2, '{3,3,0,0,0,0,0,0}, d); chk("R8 own enable clear", d, 64'd0);
   endtask

   task automatic test_layout();
      logic [63:0] v;
      wr_fn(2, 32'hA5FF_5A07);
      rd(2, v); chk("R2 reserved flags cleared", v, 64'hA5C7_5A07);
      @(negedge clk);
      rd(0, v); chk("R2 fn0 readback", v, 64'h0043_0002);
      @(negedge clk);
   endtask

   task automatic test_evsel();
      logic [63:0] b3, b1, a3, a1;
      wr_fn(3, 32'h0043_0009);
      wr_fn(1, 32'h0043_0007);
      rd(7, b3); @(negedge clk);
      rd(5, b1); @(negedge clk);
      evt_cnt = 32'h5555_5555;
      repeat (3) @(negedge clk);
      evt_cnt = '0;
      rd(7, a3); @(negedge clk);
      rd(5, a1); @(negedge clk);
      chk("R9 select beyond range", a3 - b3, 64'd0);
      chk("R9 top valid select", a1 - b1, 64'd15);
   endtask

   task automatic test_tsc();
      logic [63:0] t0, t1;
      rd(8, t0);
      repeat (10) @(negedge clk);
      rd(8, t1);
      chk("R12 tsc step", t1 - t0, 64'd10);
   endtask

   task automatic test_snap();
      logic [63:0] c [4];
      logic [63:0] t;
      wr_fn(0, 32'h0003_0002);
      for (int i = 0; i < 4; i++) begin
         rd(4 + i, c[i]); @(negedge clk);
      end
      rd(8, t);
      snap_req = 1'b1;
      @(negedge clk);
      snap_req = 1'b0;
      chk("R13 snap_valid high", {63'd0, snap_valid}, 64'd1);
      chk("R13 snap tsc", snap_tsc, t);
      for (int i = 0; i < 4; i++)
         chk("R13 snap ctr", {24'd0, snap_ctr[i*40 +: 40]}, c[i]);
      @(negedge clk);
      chk("R13 snap_valid pulse", {63'd0, snap_valid}, 64'd0);
      wr_fn(0, 32'h0043_0002);
   endtask

   task automatic test_wrap();
      w_we = 1'b1; w_idx = '0; w_wdata = 32'h0043_0000;
      @(negedge clk);
      w_we = 1'b0;
      w_evt = 8'h0F;
      repeat (18) @(negedge clk);
      w_evt = '0;
      w_rd_addr = 2'd1;
      #1;
      chk("R11 counter wrap", w_rd_data, 64'd14);
      @(negedge clk);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      test_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_full();
      test_thresh();
      test_invert();
      test_mode();
      test_edge();
      test_edge_clear();
      test_enable();
      test_layout();
      test_evsel();
      test_tsc();
      test_snap();
      test_wrap();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule